// File: doc/BRIEF.md
# Open-Page SDRAM Burst Sequencer

This block drives the command pins of an SDRAM for one memory area of a bus controller. It keeps rows open between accesses: a table records, for each internal bank, whether a row is open and which row it is. When a request targets the open row of its bank, the block goes straight to the column cycles. When the bank holds a different row, the block precharges that bank and activates the new row first. When the bank is closed, it only activates. Every transfer is a fixed burst of column-command and data cycles, followed by one data-end cycle.

A refresh request or a release of the bus to another master closes every bank with a precharge-all command, and the table is cleared to match. A refresh request wins over a waiting access. The CAS latency is an input. At a latency of one, an idle cycle follows the first column command, so that the byte-mask timing holds. At larger latencies no such cycle is added. Requests tagged with another area number are not accepted, and they leave the row table untouched.

The request address is split as {row, bank, column}, with the column in the low bits. A request is accepted in the cycle in which `grant` is high, and `done` marks the data-end cycle of its burst.

Top module: `sdram_openpage_ctrl`

## Requirements
- R1: For a request to the open row of its bank (a hit), no activate or precharge is issued, and the first column command appears in the cycle right after `grant`.
- R2: For a request to a bank whose open row differs from the requested row, the cycles after `grant` are a precharge of that bank (A10 low), an activate of the new row, and then the burst.
- R3: For a request to a closed bank, the cycle after `grant` is an activate of the requested row (row on `sd_addr`, bank on `sd_ba`), followed by the burst, and the bank then counts as open.
- R4: A request whose area differs from `MY_AREA` gets no `grant` and issues no command, because `sd_cs_n` stays high. It changes no bank's open-row state.
- R5: With `ref_req` high in idle, `grant` stays low even if a request is present. The next cycles are a precharge-all (A10 high), a refresh command with `ref_ack` high, and `RFC_CYC` NOP cycles, after which the block is idle and all banks are closed.
- R6: With `bus_release` high in idle, the block issues a precharge-all and then deselects while `bus_release` stays high. All banks are then closed.
- R7: A burst is `BURST` pairs of a column cycle and a data cycle, followed by one data-end cycle. Column command k carries column (start column + k) modulo 2^`COL_W`. Commands on {cs_n,ras_n,cas_n,we_n} are: deselect 1111, NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, refresh 0001.
- R8: With `cas_lat` equal to 1 (0 is treated as 1), exactly one NOP cycle follows the first column command of a burst. With `cas_lat` of 2 or 3, no cycle is inserted.
- R9: `sd_dqm` is all ones in every cycle except data cycles, where it equals the inverse of the request's byte enables.
- R10: `done` is high for exactly the data-end cycle, and a request presented in the next cycle is granted in that cycle.
- R11: After reset, `sd_cs_n` is high, `grant` and `done` are low, and all banks are closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ROW_W+BANK_W+COL_W | Request address {row, bank, column} |
| req_write | input | 1 | 1 for a write burst, 0 for a read burst |
| req_area | input | AREA_W | Memory area of the request |
| req_be | input | LANES | Byte-lane enables of the request |
| cas_lat | input | 2 | CAS latency, 1 to 3 |
| ref_req | input | 1 | Refresh request |
| bus_release | input | 1 | Bus handed to another master |
| grant | output | 1 | Request accepted this cycle |
| done | output | 1 | Data-end cycle of the burst |
| ref_ack | output | 1 | Refresh command issued this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Row, or zero-extended column |
| sd_a10 | output | 1 | All-bank select on precharge |
| sd_dqm | output | LANES | Byte mask, high masks a lane |

## Verification
The assertions check on every cycle the rules that relate one cycle to the next: a precharge is followed by an activate, a hit goes straight to a column cycle, the latency-one gap appears or is absent, a refresh is preceded by a precharge-all and finds every bank closed, the byte mask is high on row cycles, and requests from other areas are never granted. Only the bench's scenarios can show that the hit, miss or closed decision follows the history of earlier accesses, refreshes and bus releases. The same holds for the full command sequence of each burst, its wrapped column addresses, and the timing of `done` against the next grant. The bench checks these against its own model of the open rows, sweeping every CAS latency over many bank and row patterns.

// File: rtl/sdram_op_pkg.sv
// Shared types for the open-page SDRAM sequencer.
// Assumes command pins are ordered {cs_n, ras_n, cas_n, we_n}.
package sdram_op_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,   // waiting for a request, refresh or bus release
        ST_PRE,    // precharge of one bank (row miss)
        ST_ACT,    // row activate
        ST_COL,    // column read/write command
        ST_GAP,    // latency-one idle cycle
        ST_DAT,    // data cycle
        ST_DEND,   // data-end cycle
        ST_RPALL,  // precharge-all ahead of refresh
        ST_REF,    // refresh command
        ST_RWAIT,  // refresh recovery
        ST_XPALL,  // precharge-all ahead of bus release
        ST_HOLD    // bus released, deselected
    } seq_state_t;

    typedef enum logic [1:0] {
        LK_HIT,
        LK_MISS,
        LK_CLOSED
    } lookup_t;

    localparam logic [3:0] CMD_DESEL = 4'b1111;
    localparam logic [3:0] CMD_NOP   = 4'b0111;
    localparam logic [3:0] CMD_ACT   = 4'b0011;
    localparam logic [3:0] CMD_RD    = 4'b0101;
    localparam logic [3:0] CMD_WR    = 4'b0100;
    localparam logic [3:0] CMD_PRE   = 4'b0010;
    localparam logic [3:0] CMD_REF   = 4'b0001;

endpackage

// File: rtl/sdram_row_table.sv
// Open-row table: one valid bit and one row register per internal bank.
// Classifies a lookup as hit, miss or closed. An activate updates one
// entry, and a precharge-all clears every valid bit. Clear wins over update.
module sdram_row_table
    import sdram_op_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output lookup_t           lk_kind,
    input  logic              upd_en,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    input  logic              clr_all,
    output logic [(1<<BANK_W)-1:0] bank_open
);
    localparam int BANKS = 1 << BANK_W;

    logic [ROW_W-1:0] row_q [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        // Per-bank entry: clear on precharge-all, load on activate.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_open[b] <= 1'b0;
                row_q[b]     <= '0;
            end else if (clr_all) begin
                bank_open[b] <= 1'b0;
            end else if (upd_en && upd_bank == BANK_W'(b)) begin
                bank_open[b] <= 1'b1;
                row_q[b]     <= upd_row;
            end
        end
    end

    // Classify the incoming request against its bank's entry.
    always_comb begin
        if (!bank_open[lk_bank])          lk_kind = LK_CLOSED;
        else if (row_q[lk_bank] == lk_row) lk_kind = LK_HIT;
        else                               lk_kind = LK_MISS;
    end

    // R3: an activate leaves its bank open.
    p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !clr_all |=> bank_open[$past(upd_bank)]);

    // R5/R6: a precharge-all leaves no bank open.
    p_clear_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> bank_open == '0);

endmodule

// File: rtl/sdram_burst_seq.sv
// Cycle sequencer: walks precharge/activate/column/data/data-end for an
// accepted request, and precharge-all plus refresh or bus hold otherwise.
// Assumes `start` is asserted only while `idle` is high.
module sdram_burst_seq
    import sdram_op_pkg::*;
#(
    parameter int ROW_W   = 8,
    parameter int BANK_W  = 2,
    parameter int COL_W   = 4,
    parameter int LANES   = 4,
    parameter int BURST   = 4,
    parameter int RFC_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cas_lat,
    input  logic              ref_req,
    input  logic              bus_release,
    input  logic              start,
    input  lookup_t           start_kind,
    input  logic [ROW_W-1:0]  start_row,
    input  logic [BANK_W-1:0] start_bank,
    input  logic [COL_W-1:0]  start_col,
    input  logic              start_wr,
    input  logic [LANES-1:0]  start_be,
    output seq_state_t        state,
    output logic [COL_W-1:0]  col_now,
    output logic [ROW_W-1:0]  row_q,
    output logic [BANK_W-1:0] bank_q,
    output logic              wr_q,
    output logic [LANES-1:0]  be_q,
    output logic              idle,
    output logic              done,
    output logic              ref_ack,
    output logic              tbl_upd,
    output logic              tbl_clr
);
    localparam int BEAT_W = (BURST > 1) ? $clog2(BURST) : 1;
    localparam int RC_W   = (RFC_CYC > 1) ? $clog2(RFC_CYC) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST - 1);
    localparam logic [RC_W-1:0]   RC_LOAD   = RC_W'(RFC_CYC - 1);

    seq_state_t        nxt;
    logic [BEAT_W-1:0] beat;
    logic [RC_W-1:0]   rcnt;
    logic [COL_W-1:0]  col_q;
    logic              cl_one;

    assign cl_one = (cas_lat <= 2'd1);

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: begin
                if (ref_req)          nxt = ST_RPALL;
                else if (bus_release) nxt = ST_XPALL;
                else if (start) begin
                    case (start_kind)
                        LK_HIT:  nxt = ST_COL;
                        LK_MISS: nxt = ST_PRE;
                        default: nxt = ST_ACT;
                    endcase
                end
            end
            ST_PRE:   nxt = ST_ACT;
            ST_ACT:   nxt = ST_COL;
            ST_COL:   nxt = (beat == '0 && cl_one) ? ST_GAP : ST_DAT;
            ST_GAP:   nxt = ST_DAT;
            ST_DAT:   nxt = (beat == LAST_BEAT) ? ST_DEND : ST_COL;
            ST_DEND:  nxt = ST_IDLE;
            ST_RPALL: nxt = ST_REF;
            ST_REF:   nxt = ST_RWAIT;
            ST_RWAIT: nxt = (rcnt == '0) ? ST_IDLE : ST_RWAIT;
            ST_XPALL: nxt = ST_HOLD;
            ST_HOLD:  nxt = bus_release ? ST_HOLD : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Beat counter: advances after each data cycle, cleared in idle.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE)  beat <= '0;
        else if (state == ST_DAT)        beat <= (beat == LAST_BEAT) ? '0 : beat + 1'b1;
    end

    // Refresh recovery counter, loaded while the refresh command is out.
    always_ff @(posedge clk) begin
        if (!rst_n)                                rcnt <= '0;
        else if (state == ST_REF)                  rcnt <= RC_LOAD;
        else if (state == ST_RWAIT && rcnt != '0)  rcnt <= rcnt - 1'b1;
    end

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0; bank_q <= '0; col_q <= '0; wr_q <= 1'b0; be_q <= '0;
        end else if (start && state == ST_IDLE) begin
            row_q  <= start_row;
            bank_q <= start_bank;
            col_q  <= start_col;
            wr_q   <= start_wr;
            be_q   <= start_be;
        end
    end

    assign col_now = col_q + COL_W'(beat);
    assign idle    = (state == ST_IDLE);
    assign done    = (state == ST_DEND);
    assign ref_ack = (state == ST_REF);
    assign tbl_upd = (state == ST_ACT);
    assign tbl_clr = (state == ST_RPALL) || (state == ST_XPALL);

    // R1: a hit goes straight to a column cycle.
    p_hit_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start && idle && !ref_req && !bus_release && start_kind == LK_HIT |=> state == ST_COL);

    // R2: a single-bank precharge is always followed by an activate.
    p_pre_then_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PRE |=> state == ST_ACT);

    // R8: latency one inserts the gap after the first column cycle.
    p_gap_cl1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_COL && beat == '0 && cl_one |=> state == ST_GAP);

    // R8: latency two or more never inserts the gap.
    p_nogap_cl2_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_COL && !cl_one |=> state == ST_DAT);

    // R5: a refresh is issued only right after a precharge-all.
    p_ref_after_pall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_REF) |-> $past(state) == ST_RPALL);

    // R6: the block stays deselected while the bus remains released.
    p_hold_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HOLD && bus_release |=> state == ST_HOLD);

endmodule

// File: rtl/sdram_cmd_drive.sv
// Pin decoder: maps the sequencer state and captured request onto the
// SDRAM command, address, all-bank bit and byte mask. Purely combinational.
module sdram_cmd_drive
    import sdram_op_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int BANK_W = 2,
    parameter int COL_W  = 4,
    parameter int LANES  = 4
) (
    input  seq_state_t        state,
    input  logic [ROW_W-1:0]  row_q,
    input  logic [BANK_W-1:0] bank_q,
    input  logic [COL_W-1:0]  col_now,
    input  logic              wr_q,
    input  logic [LANES-1:0]  be_q,
    output logic [3:0]        cmd,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr,
    output logic              a10,
    output logic [LANES-1:0]  dqm
);
    // Command, address and mask per state.
    always_comb begin
        cmd  = CMD_DESEL;
        addr = '0;
        a10  = 1'b0;
        ba   = bank_q;
        dqm  = '1;
        case (state)
            ST_PRE:                     cmd = CMD_PRE;
            ST_ACT: begin               cmd = CMD_ACT; addr = row_q; end
            ST_COL: begin
                cmd  = wr_q ? CMD_WR : CMD_RD;
                addr = ROW_W'(col_now);
            end
            ST_DAT: begin               cmd = CMD_NOP; dqm = ~be_q; end
            ST_GAP, ST_DEND, ST_RWAIT:  cmd = CMD_NOP;
            ST_RPALL, ST_XPALL: begin   cmd = CMD_PRE; a10 = 1'b1; end
            ST_REF:                     cmd = CMD_REF;
            default:                    cmd = CMD_DESEL;
        endcase
    end

endmodule

// File: rtl/sdram_openpage_ctrl.sv
// Open-page SDRAM controller for one memory area. Filters requests by
// area, applies refresh and bus-release priority, and joins row table,
// sequencer and pin decoder. Assumes ROW_W >= COL_W and request fields
// stay stable in the cycle they are granted.
module sdram_openpage_ctrl
    import sdram_op_pkg::*;
#(
    parameter int ROW_W   = 8,
    parameter int BANK_W  = 2,
    parameter int COL_W   = 4,
    parameter int LANES   = 4,
    parameter int AREA_W  = 3,
    parameter int MY_AREA = 3,
    parameter int BURST   = 4,
    parameter int RFC_CYC = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [ROW_W+BANK_W+COL_W-1:0] req_addr,
    input  logic                          req_write,
    input  logic [AREA_W-1:0]             req_area,
    input  logic [LANES-1:0]              req_be,
    input  logic [1:0]                    cas_lat,
    input  logic                          ref_req,
    input  logic                          bus_release,
    output logic                          grant,
    output logic                          done,
    output logic                          ref_ack,
    output logic                          sd_cs_n,
    output logic                          sd_ras_n,
    output logic                          sd_cas_n,
    output logic                          sd_we_n,
    output logic [BANK_W-1:0]             sd_ba,
    output logic [ROW_W-1:0]              sd_addr,
    output logic                          sd_a10,
    output logic [LANES-1:0]              sd_dqm
);
    localparam int BANKS = 1 << BANK_W;
    localparam logic [AREA_W-1:0] AREA_ID = AREA_W'(MY_AREA);

    logic [ROW_W-1:0]  in_row;
    logic [BANK_W-1:0] in_bank;
    logic [COL_W-1:0]  in_col;
    logic              area_hit;
    logic              idle;
    lookup_t           kind;
    seq_state_t        state;
    logic [COL_W-1:0]  col_now;
    logic [ROW_W-1:0]  row_q;
    logic [BANK_W-1:0] bank_q;
    logic              wr_q;
    logic [LANES-1:0]  be_q;
    logic              tbl_upd;
    logic              tbl_clr;
    logic [BANKS-1:0]  bank_open;
    logic [3:0]        cmd;

    assign {in_row, in_bank, in_col} = req_addr;
    assign area_hit = (req_area == AREA_ID);
    assign grant    = idle && req_valid && area_hit && !ref_req && !bus_release;

    sdram_row_table #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .lk_bank(in_bank), .lk_row(in_row), .lk_kind(kind),
        .upd_en(tbl_upd), .upd_bank(bank_q), .upd_row(row_q),
        .clr_all(tbl_clr), .bank_open(bank_open)
    );

    sdram_burst_seq #(
        .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .LANES(LANES),
        .BURST(BURST), .RFC_CYC(RFC_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat),
        .ref_req(ref_req), .bus_release(bus_release),
        .start(grant), .start_kind(kind),
        .start_row(in_row), .start_bank(in_bank), .start_col(in_col),
        .start_wr(req_write), .start_be(req_be),
        .state(state), .col_now(col_now), .row_q(row_q), .bank_q(bank_q),
        .wr_q(wr_q), .be_q(be_q), .idle(idle), .done(done), .ref_ack(ref_ack),
        .tbl_upd(tbl_upd), .tbl_clr(tbl_clr)
    );

    sdram_cmd_drive #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .LANES(LANES)) u_drive (
        .state(state), .row_q(row_q), .bank_q(bank_q), .col_now(col_now),
        .wr_q(wr_q), .be_q(be_q),
        .cmd(cmd), .ba(sd_ba), .addr(sd_addr), .a10(sd_a10), .dqm(sd_dqm)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    // R4: requests for another area are never accepted.
    p_other_area_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !area_hit |-> !grant);

    // R5: a pending refresh blocks acceptance.
    p_ref_priority_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> !grant);

    // R5: the refresh command finds every bank closed.
    p_ref_all_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_REF |-> bank_open == '0);

    // R9: row commands keep every lane masked.
    p_dqm_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT || cmd == CMD_PRE) |-> sd_dqm == '1);

    // R10: done lasts a single cycle.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/sdram_openpage_ctrl_tb.sv
`timescale 1ns/1ps
module sdram_openpage_ctrl_tb;
    localparam int ROW_W = 8, BANK_W = 2, COL_W = 4, LANES = 4;
    localparam int AREA_W = 3, MY_AREA = 3, BURST = 4, RFC_CYC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ROW_W+BANK_W+COL_W-1:0] req_addr = '0;
    logic req_write = 1'b0;
    logic [AREA_W-1:0] req_area = '0;
    logic [LANES-1:0] req_be = '0;
    logic [1:0] cas_lat = 2'd2;
    logic ref_req = 1'b0;
    logic bus_release = 1'b0;
    logic grant, done, ref_ack, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10;
    logic [BANK_W-1:0] sd_ba;
    logic [ROW_W-1:0] sd_addr;
    logic [LANES-1:0] sd_dqm;

    int errors = 0;
    int checks = 0;

    logic       m_open [4];
    logic [7:0] m_row  [4];

    // expected per-cycle trace of one access
    logic [3:0] e_cmd  [0:15];
    logic [3:0] e_dqm  [0:15];
    logic       e_done [0:15];
    logic       e_adck [0:15];
    logic [7:0] e_addr [0:15];
    string      e_tag  [0:15];

    always #4 clk = ~clk;

    sdram_openpage_ctrl #(
        .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .LANES(LANES),
        .AREA_W(AREA_W), .MY_AREA(MY_AREA), .BURST(BURST), .RFC_CYC(RFC_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_area(req_area), .req_be(req_be),
        .cas_lat(cas_lat), .ref_req(ref_req), .bus_release(bus_release),
        .grant(grant), .done(done), .ref_ack(ref_ack),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_a10(sd_a10), .sd_dqm(sd_dqm)
    );

    function automatic logic [3:0] pins();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic clear_model();
        for (int b = 0; b < 4; b++) m_open[b] = 1'b0;
    endtask

    // One request; starts and ends on a falling edge with the block idle.
    task automatic do_access(input int bank, input int row, input int col, input bit wr,
                             input logic [3:0] be);
        int n = 0;
        string kt;
        bit hit, miss;
        hit  = m_open[bank] && m_row[bank] == 8'(row);
        miss = m_open[bank] && !hit;
        kt   = hit ? "R1" : (miss ? "R2" : "R3");
        if (miss) begin
            e_cmd[n] = 4'b0010; e_dqm[n] = 4'hF; e_done[n] = 0; e_adck[n] = 0; e_addr[n] = 0; e_tag[n] = "R2"; n++;
        end
        if (!hit) begin
            e_cmd[n] = 4'b0011; e_dqm[n] = 4'hF; e_done[n] = 0; e_adck[n] = 1; e_addr[n] = 8'(row); e_tag[n] = kt; n++;
        end
        for (int k = 0; k < BURST; k++) begin
            e_cmd[n] = wr ? 4'b0100 : 4'b0101; e_dqm[n] = 4'hF; e_done[n] = 0; e_adck[n] = 1;
            e_addr[n] = 8'((col + k) % 16); e_tag[n] = (k == 0) ? kt : "R7"; n++;
            if (k == 0 && cas_lat <= 2'd1) begin
                e_cmd[n] = 4'b0111; e_dqm[n] = 4'hF; e_done[n] = 0; e_adck[n] = 0; e_addr[n] = 0; e_tag[n] = "R8"; n++;
            end
            e_cmd[n] = 4'b0111; e_dqm[n] = ~be; e_done[n] = 0; e_adck[n] = 0; e_addr[n] = 0;
            e_tag[n] = (k == 0) ? "R8" : "R9"; n++;
        end
        e_cmd[n] = 4'b0111; e_dqm[n] = 4'hF; e_done[n] = 1; e_adck[n] = 0; e_addr[n] = 0; e_tag[n] = "R10"; n++;

        req_valid = 1'b1; req_area = AREA_W'(MY_AREA); req_write = wr; req_be = be;
        req_addr = {8'(row), 2'(bank), 4'(col)};
        #1 chk(grant == 1'b1, "R10", "grant on idle request", grant, 1);
        for (int s = 0; s < n; s++) begin
            @(negedge clk);
            if (s == 0) req_valid = 1'b0;
            chk(pins() == e_cmd[s], e_tag[s], $sformatf("cmd step %0d", s), pins(), e_cmd[s]);
            chk(sd_dqm == e_dqm[s], "R9", $sformatf("dqm step %0d", s), sd_dqm, e_dqm[s]);
            chk(done == e_done[s], "R10", $sformatf("done step %0d", s), done, e_done[s]);
            if (e_adck[s]) begin
                chk(sd_addr == e_addr[s], (e_cmd[s] == 4'b0011) ? kt : "R7",
                    $sformatf("addr step %0d", s), sd_addr, e_addr[s]);
                chk(sd_ba == 2'(bank), kt, $sformatf("bank step %0d", s), sd_ba, bank);
            end
            if (e_cmd[s] == 4'b0010) chk(sd_a10 == 1'b0, "R2", "single-bank precharge a10", sd_a10, 0);
        end
        @(negedge clk);
        m_open[bank] = 1'b1;
        m_row[bank]  = 8'(row);
    endtask

    // Refresh, optionally with a competing request held throughout.
    task automatic do_refresh(input bit with_req);
        if (with_req) begin
            req_valid = 1'b1; req_area = AREA_W'(MY_AREA);
            req_addr = {8'd7, 2'd1, 4'd2}; req_write = 1'b0; req_be = 4'hF;
        end
        ref_req = 1'b1;
        #1 chk(grant == 1'b0, "R5", "grant with refresh pending", grant, 0);
        @(negedge clk);
        chk(pins() == 4'b0010, "R5", "precharge-all cmd", pins(), 4'b0010);
        chk(sd_a10 == 1'b1, "R5", "precharge-all a10", sd_a10, 1);
        @(negedge clk);
        chk(pins() == 4'b0001, "R5", "refresh cmd", pins(), 4'b0001);
        chk(ref_ack == 1'b1, "R5", "ref_ack", ref_ack, 1);
        ref_req = 1'b0; req_valid = 1'b0;
        for (int w = 0; w < RFC_CYC; w++) begin
            @(negedge clk);
            chk(pins() == 4'b0111, "R5", "refresh recovery nop", pins(), 4'b0111);
        end
        @(negedge clk);
        chk(pins() == 4'b1111, "R5", "idle after refresh", pins(), 4'b1111);
        clear_model();
    endtask

    task automatic do_release();
        bus_release = 1'b1;
        #1 chk(grant == 1'b0, "R6", "grant during release", grant, 0);
        @(negedge clk);
        chk(pins() == 4'b0010 && sd_a10, "R6", "precharge-all before release", {pins(), sd_a10}, 5'b00101);
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            chk(pins() == 4'b1111, "R6", "deselect while released", pins(), 4'b1111);
        end
        bus_release = 1'b0;
        @(negedge clk);
        chk(pins() == 4'b1111, "R6", "idle after release", pins(), 4'b1111);
        clear_model();
    endtask

    task automatic other_area(input int bank, input int row);
        req_valid = 1'b1; req_area = AREA_W'(MY_AREA + 1);
        req_addr = {8'(row + 40), 2'(bank), 4'd0};
        for (int c = 0; c < 3; c++) begin
            #1 chk(grant == 1'b0, "R4", "grant for other area", grant, 0);
            @(negedge clk);
            chk(pins() == 4'b1111, "R4", "no command for other area", pins(), 4'b1111);
        end
        req_valid = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(sd_cs_n == 1'b1, "R11", "reset cs_n", sd_cs_n, 1);
        chk(grant == 1'b0 && done == 1'b0, "R11", "reset grant/done", {grant, done}, 0);
        @(negedge clk);
        for (int cl = 1; cl <= 3; cl++) begin
            cas_lat = 2'(cl);
            for (int i = 0; i < 24; i++) begin
                int bank = i % 4;
                int row  = (i / 8) % 2 + cl * 3;
                if (i % 7 == 3) other_area(bank, row);
                if (i == 12) do_release();
                if (i == 18) do_refresh(1'b1);
                do_access(bank, row, (i * 5 + cl) % 16, i[0], 4'((i * 7 + cl) % 16));
            end
            do_refresh(1'b0);
        end
        // cas_lat of zero behaves as one
        cas_lat = 2'd0;
        do_access(2, 9, 14, 1'b0, 4'h5);
        do_access(2, 9, 15, 1'b1, 4'hA);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule